// File: doc/BRIEF.md
# Page-Aware Flash Read Controller

This block sits on the host side of a parallel flash that reads a whole page of words internally. The first read into a page pays the full initial access time. Later reads that stay inside the same page return much sooner. The controller remembers the page of the last read it issued. For each new request it compares the page bits of the address with that stored page and loads its wait-state timer with either the short in-page count or the long initial count. Eight same-page reads therefore cost one long access plus seven short ones, not eight long ones.

Host requests arrive on a valid/ready channel. The host raises `req_valid` with address, direction and write data, and holds all of them stable until it sees `req_ready`. This is the only back-pressure in the block. The controller accepts the request on the first clock edge at which it is idle and `req_valid` is high. It then keeps `req_ready` low for the whole wait period and raises it for exactly one cycle, the last cycle of the access. The handshake completes at the edge that ends that cycle. Read data comes back one cycle later on `rsp_valid`/`rsp_data`. This channel has no back-pressure, so the host must take the data in the cycle it is shown. Writes go straight to the flash with initial-access timing and give no response. Two saturating counters report how many reads hit the stored page and how many missed it.

The page is the address with its low offset bits dropped: 3 bits for an 8-word page, or 4 bits when the parameter `BYTE_MODE` is set, which gives a 16-byte page. Any write or reset invalidates the stored page. So does any idle clock edge with no request pending, because chip select is released at that edge.

Top module: `page_flash_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released: `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_drive` is 0, `req_ready` and `rsp_valid` are 0, and both counters are 0.
- R2: An idle controller accepts a request at the first edge with `req_valid` high. `req_ready` is high for exactly one cycle per access, the last one. No further request is taken until that access ends.
- R3: A read is a miss when no page is stored or when the request's page bits `req_addr[ADDR_W-1:3]` (default) differ from the stored page. A miss keeps `fl_ce_n`=0 and `fl_oe_n`=0 for INIT_WAIT cycles (default 9), with `req_ready` high in the last of them.
- R4: A read whose page bits equal the stored page, while the stored page is valid, is a hit and lasts PAGE_WAIT cycles (default 3).
- R5: One cycle after the handshake edge of a read, `rsp_valid` is 1 for one cycle. `rsp_data` then carries the value of `fl_dq_in` at that edge.
- R6: The stored page becomes invalid on reset, on every accepted write, and on every edge at which the controller is idle with `req_valid` low. At that idle edge `fl_ce_n` and `fl_oe_n` go to 1. A following read to the old page is then a miss.
- R7: A write drives `fl_ce_n`=0, `fl_we_n`=0 and `fl_oe_n`=1, and drives `fl_dq_drive`=1 with `fl_dq_out` equal to the write data, for INIT_WAIT cycles. It raises no `rsp_valid` and leaves both counters unchanged.
- R8: Each accepted read adds one to exactly one of `hit_count` or `miss_count`. Each counter stops at 2^CNT_W-1.
- R9: Eight back-to-back reads to one page take 8 + INIT_WAIT + 7*PAGE_WAIT cycles, counted from presenting the first request to the edge after the last handshake.
- R10: Throughout an access `fl_addr` holds the accepted address and `fl_ce_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | High in the last cycle of the access; the handshake completes at the edge that ends it |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flash address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_data | output | DATA_W | Read data |
| fl_addr | output | ADDR_W | Address to the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_dq_out | output | DATA_W | Data driven to the flash on writes |
| fl_dq_drive | output | 1 | High when `fl_dq_out` should drive the data bus |
| fl_dq_in | input | DATA_W | Data returned by the flash |
| hit_count | output | CNT_W | Saturating count of page hits |
| miss_count | output | CNT_W | Saturating count of page misses |

## Verification
All flash pins and both counters change one edge after the acceptance edge. On a miss `req_ready` rises INIT_WAIT-1 edges after acceptance, and on a hit PAGE_WAIT-1 edges after. `rsp_valid` follows one edge after the handshake. The bench drives inputs on falling edges and advances a behavioural model at every rising edge. At the following falling edge it compares every output with that model, so each result is checked in the cycle it is due and in no other. Directed checks add the eight-read cycle total, the counter totals after each phase, and saturation, which is reached with a narrow counter width.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic {
    PFC_IDLE = 1'b0,
    PFC_BUSY = 1'b1
  } pfc_state_e;

  // Registered strobes toward the flash device.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pfc_ctl_t;

  localparam pfc_ctl_t PFC_CTL_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/pfc_page_tracker.sv
module pfc_page_tracker #(
  parameter int PAGE_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [PAGE_W-1:0] page_in,
  output logic              hit,
  output logic              valid
);

  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      valid  <= 1'b0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      page_q <= page_in;
      valid  <= 1'b1;
    end
  end

  assign hit = valid && (page_q == page_in);

endmodule

// File: rtl/pfc_wait_timer.sv
module pfc_wait_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pfc_sat_counter.sv
module pfc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (inc && !(&value)) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/page_flash_ctrl.sv
module page_flash_ctrl
  import pfc_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int DATA_W          = 16,
  parameter int PAGE_WORD_BITS  = 3,
  parameter int BYTE_MODE       = 0,
  parameter int INIT_WAIT       = 9,
  parameter int PAGE_WAIT       = 3,
  parameter int CNT_W           = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_drive,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  // Offset bits inside a page; byte addressing adds one more.
  localparam int OFS_W    = PAGE_WORD_BITS + ((BYTE_MODE != 0) ? 1 : 0);
  localparam int PAGE_W   = ADDR_W - OFS_W;
  localparam int MAX_WAIT = (INIT_WAIT > PAGE_WAIT) ? INIT_WAIT : PAGE_WAIT;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
  localparam logic [WAIT_W-1:0] INIT_LOAD = WAIT_W'(INIT_WAIT - 1);
  localparam logic [WAIT_W-1:0] PAGE_LOAD = WAIT_W'(PAGE_WAIT - 1);

  pfc_state_e state_q;
  pfc_ctl_t   ctl_q;
  logic       wr_q;

  logic              busy;
  logic              pg_hit;
  logic              pg_valid;
  logic              timer_done;
  logic              start;
  logic              start_rd;
  logic              start_wr;
  logic              finish;
  logic              idle_gap;
  logic [PAGE_W-1:0] req_page;
  logic [WAIT_W-1:0] wait_load;

  assign busy     = (state_q == PFC_BUSY);
  assign start    = !busy && req_valid;
  assign start_rd = start && !req_write;
  assign start_wr = start && req_write;
  assign finish   = busy && timer_done;
  assign idle_gap = !busy && !req_valid;
  assign req_page = req_addr[ADDR_W-1:OFS_W];

  // Wait states picked per transaction from the page comparison.
  assign wait_load = (start_rd && pg_hit) ? PAGE_LOAD : INIT_LOAD;

  pfc_page_tracker #(
    .PAGE_W (PAGE_W)
  ) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_rd),
    .clear   (start_wr || idle_gap),
    .page_in (req_page),
    .hit     (pg_hit),
    .valid   (pg_valid)
  );

  pfc_wait_timer #(
    .W (WAIT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (wait_load),
    .done     (timer_done)
  );

  pfc_sat_counter #(
    .W (CNT_W)
  ) u_hits (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (start_rd && pg_hit),
    .value (hit_count)
  );

  pfc_sat_counter #(
    .W (CNT_W)
  ) u_misses (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (start_rd && !pg_hit),
    .value (miss_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PFC_IDLE;
    end else if (start) begin
      state_q <= PFC_BUSY;
    end else if (finish) begin
      state_q <= PFC_IDLE;
    end
  end

  // Flash pin registers: asserted at acceptance, write strobe dropped at the
  // end of the access, chip select released only on an idle edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= PFC_CTL_OFF;
      wr_q      <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
    end else if (start) begin
      ctl_q.ce_n  <= 1'b0;
      ctl_q.oe_n  <= req_write;
      ctl_q.we_n  <= !req_write;
      ctl_q.drive <= req_write;
      wr_q        <= req_write;
      fl_addr     <= req_addr;
      if (req_write) begin
        fl_dq_out <= req_wdata;
      end
    end else if (finish) begin
      ctl_q.we_n  <= 1'b1;
      ctl_q.drive <= 1'b0;
    end else if (idle_gap) begin
      ctl_q.ce_n <= 1'b1;
      ctl_q.oe_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= finish && !wr_q;
      if (finish && !wr_q) begin
        rsp_data <= fl_dq_in;
      end
    end
  end

  assign req_ready   = finish;
  assign fl_ce_n     = ctl_q.ce_n;
  assign fl_oe_n     = ctl_q.oe_n;
  assign fl_we_n     = ctl_q.we_n;
  assign fl_dq_drive = ctl_q.drive;

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic              fl_dq_drive,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              busy,
  input logic              pg_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);

  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R5
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_write) |=> rsp_valid);

  // R5
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_ready));

  // R7
  write_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_oe_n && !fl_ce_n && fl_dq_drive));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fl_addr) && !fl_ce_n));

  // R6
  released_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ce_n |-> !pg_valid);

  // R8
  hit_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count >= $past(hit_count));

  // R8
  miss_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count >= $past(miss_count));

endmodule

bind page_flash_ctrl pfc_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_pfc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .fl_ce_n     (fl_ce_n),
  .fl_oe_n     (fl_oe_n),
  .fl_we_n     (fl_we_n),
  .fl_dq_drive (fl_dq_drive),
  .fl_addr     (fl_addr),
  .busy        (busy),
  .pg_valid    (pg_valid),
  .hit_count   (hit_count),
  .miss_count  (miss_count)
);

// File: tb/test_page_flash_ctrl.sv
`timescale 1ns/1ps
module test_page_flash_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int IW = 9;
  localparam int PW = 3;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_drive;
  logic [DW-1:0] rsp_data, fl_dq_out, fl_dq_in;
  logic [AW-1:0] fl_addr;
  logic [CW-1:0] hit_count, miss_count;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
    return {a[3:0], a[15:4]} ^ 16'h5A3C;
  endfunction

  assign fl_dq_in = flash_word(fl_addr);

  page_flash_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .INIT_WAIT(IW), .PAGE_WAIT(PW), .CNT_W(CW)
  ) i_page_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_addr(fl_addr),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_dq_out(fl_dq_out), .fl_dq_drive(fl_dq_drive), .fl_dq_in(fl_dq_in),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced at each rising edge.
  bit m_busy = 0, m_wr = 0, m_pv = 0, m_rsp_v = 0;
  bit m_ce = 1, m_oe = 1, m_we = 1, m_drv = 0;
  int m_left = 0, m_page = 0, m_hits = 0, m_miss = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_rsp_d = '0, m_wd = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_pv = 0; m_rsp_v = 0; m_ce = 1; m_oe = 1;
      m_we = 1; m_drv = 0; m_left = 0; m_hits = 0; m_miss = 0; m_addr = '0;
    end else if (m_busy) begin
      m_rsp_v = 0;
      if (m_left == 0) begin
        m_busy = 0;
        if (!m_wr) begin m_rsp_v = 1; m_rsp_d = flash_word(m_addr); end
        m_we = 1; m_drv = 0;
      end else m_left--;
    end else begin
      m_rsp_v = 0;
      if (req_valid) begin
        m_busy = 1; m_addr = req_addr; m_ce = 0; m_wr = req_write;
        if (req_write) begin
          m_we = 0; m_oe = 1; m_drv = 1; m_wd = req_wdata; m_pv = 0; m_left = IW - 1;
        end else begin
          m_we = 1; m_oe = 0; m_drv = 0;
          if (m_pv && m_page == int'(req_addr >> 3)) begin
            m_left = PW - 1; if (m_hits < CMAX) m_hits++;
          end else begin
            m_left = IW - 1; if (m_miss < CMAX) m_miss++;
          end
          m_pv = 1; m_page = int'(req_addr >> 3);
        end
      end else begin
        m_ce = 1; m_oe = 1; m_pv = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(req_ready === (m_busy && m_left == 0), "R2/R3/R4 req_ready", req_ready, m_busy && m_left == 0);
      check(fl_ce_n === m_ce, "R10/R6 fl_ce_n", fl_ce_n, m_ce);
      check(fl_oe_n === m_oe, "R3/R6 fl_oe_n", fl_oe_n, m_oe);
      check(fl_we_n === m_we, "R7 fl_we_n", fl_we_n, m_we);
      check(fl_dq_drive === m_drv, "R7 fl_dq_drive", fl_dq_drive, m_drv);
      if (m_drv) check(fl_dq_out === m_wd, "R7 fl_dq_out", fl_dq_out, m_wd);
      if (!m_ce) check(fl_addr === m_addr, "R10 fl_addr", fl_addr, m_addr);
      check(rsp_valid === m_rsp_v, "R5 rsp_valid", rsp_valid, m_rsp_v);
      if (m_rsp_v) check(rsp_data === m_rsp_d, "R5 rsp_data", rsp_data, m_rsp_d);
      check(hit_count === CW'(m_hits), "R8 hit_count", hit_count, m_hits);
      check(miss_count === CW'(m_miss), "R8 miss_count", miss_count, m_miss);
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      bad++;
      $display("FAIL watchdog R2 cycles=%0d expected below 20000", cyc);
      finish_run();
    end
  end

  int c0;

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_drive, "R1 pins in reset",
          {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_drive}, 4'b1110);
    check(!req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1 counters after reset", {hit_count, miss_count}, 0);

    // R9: eight same-page reads back to back, scrambled order
    c0 = cyc;
    for (int k = 0; k < 8; k++) issue(1'b0, 20'h01230 | AW'((k * 5) & 7), '0);
    check(cyc - c0 == 8 + IW + 7 * PW, "R9 eight-read cycles", cyc - c0, 8 + IW + 7 * PW);
    req_valid = 1'b0;
    @(negedge clk);
    check(hit_count == 7, "R4 hits after page run", hit_count, 7);
    check(miss_count == 1, "R3 misses after page run", miss_count, 1);

    // R3/R4: page change then return
    issue(1'b0, 20'h01238, '0);
    issue(1'b0, 20'h01231, '0);
    issue(1'b0, 20'h01235, '0);
    check(miss_count == 3 && hit_count == 8, "R3 page change miss",
          {miss_count, hit_count}, {4'd3, 4'd8});

    // R6: idle gap forgets the page
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(fl_ce_n == 1'b1, "R6 chip enable released", fl_ce_n, 1);
    issue(1'b0, 20'h01235, '0);
    check(miss_count == 4, "R6 read after gap misses", miss_count, 4);
    issue(1'b0, 20'h01236, '0);
    check(hit_count == 9, "R4 hit after refill", hit_count, 9);

    // R7: write inside the page, then a read of the same page misses
    issue(1'b1, 20'h01237, 16'hBEEF);
    check(hit_count == 9 && miss_count == 4, "R7 write leaves counters",
          {hit_count, miss_count}, {4'd9, 4'd4});
    issue(1'b0, 20'h01236, '0);
    check(miss_count == 5, "R6 read after write misses", miss_count, 5);

    // R8: saturation of both counters
    for (int i = 0; i < 12; i++) issue(1'b0, 20'h01230 | AW'(i & 7), '0);
    for (int i = 0; i < 12; i++) issue(1'b0, AW'(20'h40000 + i * 8), '0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(hit_count == CMAX, "R8 hit saturation", hit_count, CMAX);
    check(miss_count == CMAX, "R8 miss saturation", miss_count, CMAX);

    finish_run();
  end

endmodule